// File: doc/BRIEF.md
# Spreading Code Generator with Phase Alignment

This block produces the 1023-chip Gold spreading sequence of one selected satellite for a navigation receiver's tracking channel. A 32-bit phase accumulator advances once per sample clock by a programmable rate word. Each carry out of the accumulator moves the on-time (prompt) chip forward by one. At the nominal rate a chip lasts 9 or 10 sample clocks, so one full code period takes about a millisecond at a 10 MHz sample clock.

The block also gives an advanced chip and a retarded chip, half a chip before and after prompt, for the early-minus-late discriminator. A one-clock epoch pulse marks each code period and is used to latch the correlation sums. A synchronous clear lines everything up with the start of a sample capture. After that, software aligns the local code to a measured code phase by holding the accumulator still for a counted number of sample clocks. The same strobe that requests a hold also writes a new rate word, so the block can follow code Doppler.

Top module: `ca_code_nco`

## Requirements
- R1: After reset: prompt and early are 1, late is 0, epoch and pausing are 0, the phase and chip index are zero, and the rate word is 439375154.
- R2: The code is the XOR of stage 10 of G1 (feedback from stages 3 and 10) with two stages of G2 (feedback from stages 2, 3, 6, 8, 9 and 10). Both registers start at all ones. The two G2 stages come from prn_sel: 0 uses stages 2 and 6, 1 uses 3 and 7, 9 uses 2 and 3, and 31 uses 4 and 9. For prn_sel 0 the first ten prompt chips are 1100100000, and for prn_sel 1 they are 1110010000.
- R3: On each unpaused clock the 32-bit phase grows by the rate word, and a carry out of bit 31 moves prompt on by one chip. The rate word must stay below 2^31. With the rate at reset, the first epoch follows the 10001st clock after reset, and the next epoch comes 10000 clocks after that.
- R4: When phase bit 31 goes from 0 to 1, early moves to the next chip and late takes the current prompt chip. On a carry, prompt takes the early chip and late takes the old prompt chip.
- R5: Epoch is high for exactly one clock. That clock is the cycle after the carry that takes the chip index from 1022 back to 0, so at 2^29 per clock the first epoch follows clock 8184 after a clear.
- R6: A ld_stb replaces the rate word. The clock that takes the strobe still adds the old rate, and the new rate is used from the next clock.
- R7: A ld_stb with hold count P, given while no hold is running, lets that clock accumulate and then freezes the phase for P clocks. During those P clocks pausing is high and prompt, late and epoch do not change, and every later event moves by P clocks.
- R8: A ld_stb that arrives while a hold is running loads the rate word but does not change the remaining hold count.
- R9: sync_clr zeroes the phase, the chip index and any hold, and restarts the code at chip 0. It keeps the rate word, unless ld_stb in the same cycle replaces it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sync_clr | input | 1 | Restart phase and code at the start of a capture |
| prn_sel | input | 5 | Satellite code select |
| ld_stb | input | 1 | Load strobe for rate word and hold count |
| ld_rate | input | 32 | New phase increment per sample clock |
| ld_pause | input | 16 | Number of sample clocks to hold the phase |
| chip_early | output | 1 | Chip half a chip ahead of prompt |
| chip_prompt | output | 1 | On-time code chip |
| chip_late | output | 1 | Chip half a chip behind prompt |
| epoch | output | 1 | One-clock pulse at each code period start |
| pausing | output | 1 | High while a hold is counting down |

## Verification
Some properties are checked on every cycle: the hand-off on each carry (early into prompt, prompt into late), the freeze of prompt and late while a hold runs, the clock-by-clock countdown of the hold, and the single-clock epoch that only occurs at chip index zero. Other behaviour only shows up in the bench's scenarios. These are the actual chip values of a given satellite, the exact clock on which an epoch lands after a rate change, a hold or a clear, and the fact that a second hold request is ignored. They need a reference sequence and long runs at controlled rates.

// File: rtl/ca_code_pkg.sv
package ca_code_pkg;

   localparam int unsigned LFSR_LEN = 10;
   localparam int unsigned CODE_LEN = 1023;
   localparam int unsigned NUM_SATS = 32;
   localparam int unsigned PRN_W    = $clog2(NUM_SATS);
   localparam int unsigned IDX_W    = $clog2(CODE_LEN);

   typedef struct packed {
      logic [3:0] a;
      logic [3:0] b;
   } tap_pair_t;

   // G2 stage pair per satellite select value
   function automatic tap_pair_t sat_taps(input logic [PRN_W-1:0] sel);
      tap_pair_t t;
      case (sel)
         5'd0:  t = '{4'd2, 4'd6};
         5'd1:  t = '{4'd3, 4'd7};
         5'd2:  t = '{4'd4, 4'd8};
         5'd3:  t = '{4'd5, 4'd9};
         5'd4:  t = '{4'd1, 4'd9};
         5'd5:  t = '{4'd2, 4'd10};
         5'd6:  t = '{4'd1, 4'd8};
         5'd7:  t = '{4'd2, 4'd9};
         5'd8:  t = '{4'd3, 4'd10};
         5'd9:  t = '{4'd2, 4'd3};
         5'd10: t = '{4'd3, 4'd4};
         5'd11: t = '{4'd5, 4'd6};
         5'd12: t = '{4'd6, 4'd7};
         5'd13: t = '{4'd7, 4'd8};
         5'd14: t = '{4'd8, 4'd9};
         5'd15: t = '{4'd9, 4'd10};
         5'd16: t = '{4'd1, 4'd4};
         5'd17: t = '{4'd2, 4'd5};
         5'd18: t = '{4'd3, 4'd6};
         5'd19: t = '{4'd4, 4'd7};
         5'd20: t = '{4'd5, 4'd8};
         5'd21: t = '{4'd6, 4'd9};
         5'd22: t = '{4'd1, 4'd3};
         5'd23: t = '{4'd4, 4'd6};
         5'd24: t = '{4'd5, 4'd7};
         5'd25: t = '{4'd6, 4'd8};
         5'd26: t = '{4'd7, 4'd9};
         5'd27: t = '{4'd8, 4'd10};
         5'd28: t = '{4'd1, 4'd6};
         5'd29: t = '{4'd2, 4'd7};
         5'd30: t = '{4'd3, 4'd8};
         default: t = '{4'd4, 4'd9};
      endcase
      return t;
   endfunction

endpackage

// File: rtl/ca_phase_acc.sv
module ca_phase_acc #(
   parameter int unsigned      ACC_W     = 32,
   parameter int unsigned      PAUSE_W   = 16,
   parameter longint unsigned  RATE_INIT = 64'd439375154
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               clr,
   input  logic               ld_stb,
   input  logic [ACC_W-1:0]   ld_rate,
   input  logic [PAUSE_W-1:0] ld_pause,
   output logic               half_rise,
   output logic               half_fall,
   output logic [PAUSE_W-1:0] pause_left
);

   localparam int unsigned MSB = ACC_W - 1;

   logic [ACC_W-1:0]   acc_q;
   logic [ACC_W-1:0]   rate_q;
   logic [PAUSE_W-1:0] pause_q;
   logic [ACC_W:0]     sum_w;
   logic               run_w;

   assign sum_w = {1'b0, acc_q} + {1'b0, rate_q};
   assign run_w = (pause_q == '0) && !clr;

   // rate below half a chip: at most one half-chip boundary per clock
   assign half_fall  = run_w && sum_w[ACC_W];
   assign half_rise  = run_w && !sum_w[ACC_W] && !acc_q[MSB] && sum_w[MSB];
   assign pause_left = pause_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q   <= '0;
         rate_q  <= ACC_W'(RATE_INIT);
         pause_q <= '0;
      end else begin
         if (ld_stb) rate_q <= ld_rate;
         if (clr) begin
            acc_q   <= '0;
            pause_q <= '0;
         end else if (pause_q != '0) begin
            pause_q <= pause_q - 1'b1;
         end else begin
            acc_q <= sum_w[ACC_W-1:0];
            if (ld_stb) pause_q <= ld_pause;
         end
      end
   end

endmodule

// File: rtl/ca_gold_seq.sv
module ca_gold_seq
   import ca_code_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             adv,
   input  logic [PRN_W-1:0] sel,
   output logic             chip
);

   localparam logic [IDX_W-1:0] LAST = IDX_W'(CODE_LEN - 1);

   logic [LFSR_LEN:1] g1_q;
   logic [LFSR_LEN:1] g2_q;
   logic [IDX_W-1:0]  idx_q;
   logic              fb1_w;
   logic              fb2_w;
   tap_pair_t         tp_w;

   assign tp_w  = sat_taps(sel);
   assign fb1_w = g1_q[3] ^ g1_q[10];
   assign fb2_w = g2_q[2] ^ g2_q[3] ^ g2_q[6] ^ g2_q[8] ^ g2_q[9] ^ g2_q[10];
   assign chip  = g1_q[10] ^ g2_q[tp_w.a] ^ g2_q[tp_w.b];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         g1_q  <= '1;
         g2_q  <= '1;
         idx_q <= '0;
      end else if (clr || (adv && idx_q == LAST)) begin
         g1_q  <= '1;
         g2_q  <= '1;
         idx_q <= '0;
      end else if (adv) begin
         g1_q  <= {g1_q[LFSR_LEN-1:1], fb1_w};
         g2_q  <= {g2_q[LFSR_LEN-1:1], fb2_w};
         idx_q <= idx_q + 1'b1;
      end
   end

endmodule

// File: rtl/ca_half_delay.sv
module ca_half_delay #(
   parameter int unsigned          STAGES  = 2,
   parameter logic [STAGES-1:0]    RST_PAT = 2'b01
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              shift,
   input  logic              din,
   output logic [STAGES-1:0] taps
);

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      logic src_w;
      if (s == 0) begin : g_head
         assign src_w = din;
      end else begin : g_body
         assign src_w = taps[s-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      taps[s] <= RST_PAT[s];
         else if (clr)    taps[s] <= RST_PAT[s];
         else if (shift)  taps[s] <= src_w;
      end
   end

endmodule

// File: rtl/ca_code_nco.sv
module ca_code_nco
   import ca_code_pkg::*;
#(
   parameter int unsigned     ACC_W     = 32,
   parameter int unsigned     PAUSE_W   = 16,
   parameter longint unsigned RATE_INIT = 64'd439375154
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               sync_clr,
   input  logic [PRN_W-1:0]   prn_sel,
   input  logic               ld_stb,
   input  logic [ACC_W-1:0]   ld_rate,
   input  logic [PAUSE_W-1:0] ld_pause,
   output logic               chip_early,
   output logic               chip_prompt,
   output logic               chip_late,
   output logic               epoch,
   output logic               pausing
);

   localparam int unsigned      CNT_W = IDX_W;
   localparam logic [CNT_W-1:0] LAST  = CNT_W'(CODE_LEN - 1);
   localparam int unsigned      TAPS  = 2;

   if (ACC_W < 16 || ACC_W > 64) begin : g_bad_acc
      $error("ca_code_nco: ACC_W out of range");
   end
   if (PAUSE_W < 1 || PAUSE_W > 32) begin : g_bad_pause
      $error("ca_code_nco: PAUSE_W out of range");
   end
   if ((RATE_INIT >> (ACC_W - 1)) != 0) begin : g_bad_rate
      $error("ca_code_nco: RATE_INIT must be below half the phase range");
   end

   logic               rise_w;
   logic               fall_w;
   logic [PAUSE_W-1:0] pause_left_w;
   logic               early_w;
   logic [TAPS-1:0]    dl_w;
   logic [CNT_W-1:0]   idx_q;
   logic               epoch_q;

   ca_phase_acc #(
      .ACC_W     (ACC_W),
      .PAUSE_W   (PAUSE_W),
      .RATE_INIT (RATE_INIT)
   ) u_acc (
      .clk        (clk),
      .rst_n      (rst_n),
      .clr        (sync_clr),
      .ld_stb     (ld_stb),
      .ld_rate    (ld_rate),
      .ld_pause   (ld_pause),
      .half_rise  (rise_w),
      .half_fall  (fall_w),
      .pause_left (pause_left_w)
   );

   // sequence runs half a chip ahead: it steps on mid-chip boundaries
   ca_gold_seq u_seq (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (sync_clr),
      .adv   (rise_w),
      .sel   (prn_sel),
      .chip  (early_w)
   );

   ca_half_delay #(
      .STAGES  (TAPS),
      .RST_PAT (2'b01)
   ) u_dly (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (sync_clr),
      .shift (rise_w | fall_w),
      .din   (early_w),
      .taps  (dl_w)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx_q   <= '0;
         epoch_q <= 1'b0;
      end else if (sync_clr) begin
         idx_q   <= '0;
         epoch_q <= 1'b0;
      end else begin
         epoch_q <= fall_w && (idx_q == LAST);
         if (fall_w) idx_q <= (idx_q == LAST) ? '0 : idx_q + 1'b1;
      end
   end

   assign chip_early  = early_w;
   assign chip_prompt = dl_w[0];
   assign chip_late   = dl_w[1];
   assign epoch       = epoch_q;
   assign pausing     = (pause_left_w != '0);

endmodule

// File: rtl/ca_code_nco_chk.sv
module ca_code_nco_chk #(
   parameter int unsigned CNT_W   = 10,
   parameter int unsigned PAUSE_W = 16
) (
   input logic               clk,
   input logic               rst_n,
   input logic               sync_clr,
   input logic               half_fall,
   input logic [CNT_W-1:0]   chip_idx,
   input logic [PAUSE_W-1:0] pause_left,
   input logic               chip_early,
   input logic               chip_prompt,
   input logic               chip_late,
   input logic               epoch,
   input logic               pausing
);

   a_r5_epoch_single: assert property (@(posedge clk) disable iff (!rst_n)
      epoch |=> !epoch);

   a_r5_epoch_at_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      epoch |-> (chip_idx == '0));

   a_r7_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (pausing && !sync_clr) |=> ($stable(chip_prompt) && $stable(chip_late) && !epoch));

   // covers R8 too: a strobe mid-hold must not disturb the countdown
   a_r7_countdown: assert property (@(posedge clk) disable iff (!rst_n)
      ((pause_left != '0) && !sync_clr) |=> (pause_left == $past(pause_left) - 1'b1));

   a_r4_handoff: assert property (@(posedge clk) disable iff (!rst_n)
      (half_fall && !sync_clr) |=>
         ((chip_prompt == $past(chip_early)) && (chip_late == $past(chip_prompt))));

endmodule

bind ca_code_nco ca_code_nco_chk #(
   .CNT_W   (CNT_W),
   .PAUSE_W (PAUSE_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .sync_clr    (sync_clr),
   .half_fall   (fall_w),
   .chip_idx    (idx_q),
   .pause_left  (pause_left_w),
   .chip_early  (chip_early),
   .chip_prompt (chip_prompt),
   .chip_late   (chip_late),
   .epoch       (epoch),
   .pausing     (pausing)
);

// File: tb/ca_code_nco_tb.sv
module ca_code_nco_tb;

   localparam longint unsigned NOM = 64'd439375154;
   localparam int unsigned     CL  = 1023;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sync_clr = 1'b0;
   logic [4:0]  prn_sel = 5'd0;
   logic        ld_stb = 1'b0;
   logic [31:0] ld_rate = 32'd0;
   logic [15:0] ld_pause = 16'd0;
   logic        chip_early, chip_prompt, chip_late, epoch, pausing;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   ca_code_nco u_dut (
      .clk(clk), .rst_n(rst_n), .sync_clr(sync_clr), .prn_sel(prn_sel),
      .ld_stb(ld_stb), .ld_rate(ld_rate), .ld_pause(ld_pause),
      .chip_early(chip_early), .chip_prompt(chip_prompt), .chip_late(chip_late),
      .epoch(epoch), .pausing(pausing)
   );

   // reference sequences for the satellites the bench uses
   bit code_tab [4][CL];

   function automatic int slot_of(input logic [4:0] s);
      case (s)
         5'd0:    return 0;
         5'd1:    return 1;
         5'd9:    return 2;
         default: return 3;
      endcase
   endfunction

   task automatic build(input int slot, input int ta, input int tb);
      logic [10:1] a = '1;
      logic [10:1] b = '1;
      for (int k = 0; k < CL; k++) begin
         logic fa, fb;
         code_tab[slot][k] = a[10] ^ b[ta] ^ b[tb];
         fa = a[3] ^ a[10];
         fb = b[2] ^ b[3] ^ b[6] ^ b[8] ^ b[9] ^ b[10];
         a = {a[9:1], fa};
         b = {b[9:1], fb};
      end
   endtask

   // behavioural model, updated on every rising edge
   logic [31:0] m_acc, m_rate;
   int          m_pause, m_n, m_slot;
   bit          m_fresh, m_epoch;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_acc = 0; m_rate = NOM[31:0]; m_pause = 0; m_n = 0;
         m_fresh = 1; m_epoch = 0; m_slot = slot_of(prn_sel);
      end else begin
         logic [31:0] old_rate;
         logic [32:0] s;
         old_rate = m_rate;
         m_epoch = 0;
         if (ld_stb) m_rate = ld_rate;
         if (sync_clr) begin
            m_acc = 0; m_pause = 0; m_n = 0; m_fresh = 1;
            m_slot = slot_of(prn_sel);
         end else if (m_pause > 0) begin
            m_pause--;
         end else begin
            s = {1'b0, m_acc} + {1'b0, old_rate};
            if (s[32]) begin
               if (m_n == CL - 1) begin m_n = 0; m_epoch = 1; end
               else m_n++;
            end
            m_acc = s[31:0];
            if (m_acc[31]) m_fresh = 0;
            if (ld_stb) m_pause = int'(ld_pause);
         end
      end
   end

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         if (n_fail <= 40) $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic cmp();
      bit pr, ea, la;
      int nx, pv;
      nx = (m_n + 1) % CL;
      pv = (m_n + CL - 1) % CL;
      pr = code_tab[m_slot][m_n];
      ea = m_acc[31] ? code_tab[m_slot][nx] : pr;
      la = m_acc[31] ? pr : (m_fresh ? 1'b0 : code_tab[m_slot][pv]);
      n_chk++;
      if (chip_prompt !== pr || chip_early !== ea || chip_late !== la ||
          epoch !== m_epoch || pausing !== (m_pause != 0)) begin
         n_fail++;
         if (n_fail <= 40)
            $display("FAIL R3/R4/R5/R7 model p/e/l/ep/ps actual=%0b%0b%0b%0b%0b expected=%0b%0b%0b%0b%0b",
                     chip_prompt, chip_early, chip_late, epoch, pausing,
                     pr, ea, la, m_epoch, (m_pause != 0));
      end
   endtask

   task automatic cyc();
      @(negedge clk);
      cmp();
   endtask

   task automatic pulse_clr(input logic [4:0] s, input bit ld, input logic [31:0] r);
      sync_clr = 1'b1; prn_sel = s; ld_stb = ld; ld_rate = r; ld_pause = 16'd0;
      cyc();
      sync_clr = 1'b0; ld_stb = 1'b0;
   endtask

   task automatic first_epoch(input int limit, output int at);
      at = -1;
      for (int j = 1; j <= limit; j++) begin
         cyc();
         if (epoch && at < 0) at = j;
      end
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         n_fail++; n_chk++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      int at, at2, pcount;
      void'($urandom(32'd20240611));
      build(0, 2, 6); build(1, 3, 7); build(2, 2, 3); build(3, 4, 9);

      // R1: reset state
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk(chip_prompt == 1'b1, "R1 prompt", chip_prompt, 1);
      chk(chip_early == 1'b1, "R1 early", chip_early, 1);
      chk(chip_late == 1'b0, "R1 late", chip_late, 0);
      chk(epoch == 1'b0 && pausing == 1'b0, "R1 epoch/pausing", {epoch, pausing}, 0);
      rst_n = 1'b1;

      // R1 R3: default rate, epoch timing
      at = -1; at2 = -1;
      for (int j = 1; j <= 20010; j++) begin
         cyc();
         if (epoch) begin if (at < 0) at = j; else if (at2 < 0) at2 = j; end
      end
      chk(at == 10001, "R3 R1 first epoch at default rate", at, 10001);
      chk(at2 - at == 10000, "R3 epoch spacing", at2 - at, 10000);

      // R2 R4 R5: satellite select 0, 8 clocks per chip
      pulse_clr(5'd0, 1'b1, 32'h2000_0000);
      at = -1; pcount = 0;
      for (int j = 1; j <= 8200; j++) begin
         int k;
         cyc();
         k = j / 8;
         if (j % 8 == 4 && k < 10) begin
            logic [9:0] pat = 10'b1100100000;
            chk(chip_prompt == pat[9-k], "R2 sel0 prompt chip", chip_prompt, pat[9-k]);
            if (k < 9) chk(chip_early == pat[8-k], "R4 early half chip ahead", chip_early, pat[8-k]);
            chk(chip_late == pat[9-k], "R4 late in second half", chip_late, pat[9-k]);
         end
         if (j % 8 == 1 && k >= 1 && k < 10) begin
            logic [9:0] pat = 10'b1100100000;
            chk(chip_late == pat[10-k], "R4 late half chip behind", chip_late, pat[10-k]);
         end
         if (j == 1) chk(chip_late == 1'b0, "R4 late before first boundary", chip_late, 0);
         if (epoch) begin pcount++; if (at < 0) at = j; end
      end
      chk(at == 8184, "R5 epoch after 1023 chips", at, 8184);
      chk(pcount == 1, "R5 single epoch pulse", pcount, 1);

      // R2 R7 R8: satellite select 1, hold of 37 with an ignored second request
      pulse_clr(5'd1, 1'b1, 32'h2000_0000);
      at = -1; pcount = 0;
      for (int j = 1; j <= 8240; j++) begin
         cyc();
         ld_stb = 1'b0;
         if (j % 8 == 4 && j / 8 < 10) begin
            logic [9:0] pat = 10'b1110010000;
            chk(chip_prompt == pat[9-(j/8)], "R2 sel1 prompt chip", chip_prompt, pat[9-(j/8)]);
         end
         if (pausing) pcount++;
         if (epoch && at < 0) at = j;
         if (j == 100) begin ld_stb = 1'b1; ld_rate = 32'h2000_0000; ld_pause = 16'd37; end
         if (j == 110) begin ld_stb = 1'b1; ld_rate = 32'h2000_0000; ld_pause = 16'd500; end
      end
      chk(pcount == 37, "R7 R8 pausing duration", pcount, 37);
      chk(at == 8184 + 37, "R7 R8 epoch delayed by hold", at, 8184 + 37);

      // R6: rate change takes effect on the clock after the strobe
      pulse_clr(5'd9, 1'b1, 32'h2000_0000);
      cyc(); cyc();
      ld_stb = 1'b1; ld_rate = 32'h4000_0000; ld_pause = 16'd0;
      cyc();
      ld_stb = 1'b0;
      first_epoch(4200, at);
      chk(at + 3 == 4094, "R6 epoch after rate change", at + 3, 4094);

      // R9: clear keeps the loaded rate
      pulse_clr(5'd31, 1'b0, 32'd0);
      first_epoch(4100, at);
      chk(at == 4092, "R9 clear keeps rate", at, 4092);

      // constrained random: Doppler-offset rates, holds, overlapping requests
      for (int seg = 0; seg < 6; seg++) begin
         logic [4:0] sels [4] = '{5'd0, 5'd1, 5'd9, 5'd31};
         longint r;
         r = longint'(NOM) + longint'($urandom_range(0, 32'h40_0000)) - 64'h20_0000;
         pulse_clr(sels[$urandom_range(0, 3)], 1'b1, r[31:0]);
         for (int j = 0; j < 9000; j++) begin
            cyc();
            ld_stb = 1'b0;
            if ($urandom_range(0, 399) == 0) begin
               r = longint'(NOM) + longint'($urandom_range(0, 32'h40_0000)) - 64'h20_0000;
               ld_stb = 1'b1; ld_rate = r[31:0];
               ld_pause = 16'($urandom_range(0, 300));
            end
         end
         ld_stb = 1'b0;
      end

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule